// File: doc/BRIEF.md
# USB Host Wrapper Configuration and Interrupt Registers

This block is a word-addressed register file that sits beside a USB host controller. A simple request/response register bus writes and reads it. It keeps the static settings that the wrapper around the controller needs, and presents each of them on a dedicated output port. The settings are a bus filter bypass, a set of port strap bits, a frame length adjustment, a byte order select, a coherency select and a bus-master enable.

The block also holds a two-source interrupt group, with one source for host system error and one for address decode error. Each source has a sticky status bit, which a hardware pulse sets and software clears by writing 1. Software cannot write the mask directly. It changes the mask through two command words: one removes mask bits and the other adds them. A single level interrupt output is high whenever an unmasked status bit is set.

An access that does not land on a defined word returns zero. It can also return an error, when software has enabled that in the register control word. In that case the error is also recorded as an address decode error.

Top module: `usb_cfg_regs`

## Requirements
- R1: After reset the frame length adjust field is 0x20, the bus-master enable is 1, the mask is 0x3, status is 0, every other field is 0 and irq_o is low.
- R2: Full-word writes to the configuration words update their outputs and read back. Bits above each field read 0 and ignore writes. The field positions are: filter bypass [3:0] at 0x30, frame adjust [5:0] at 0x38, byte order [0] at 0x40, coherency [0] at 0x44, bus-master [0] at 0x48 and slave-error enable [0] at 0x60.
- R3: The port word at 0x34 holds five bits, driven on port_strap_o[4:0] in the same bit order: permanent attach [0], power-control present [1], message interrupt enable [2], command-write notify [3] and base-address-write notify [4].
- R4: Writing 1 to a bit of the status word at 0x64 clears that bit, and writing 0 leaves it unchanged. Bit 0 is address decode error and bit 1 is host system error.
- R5: A write to the mask word at 0x68 has no effect on the mask.
- R6: Writing 1s to 0x6C clears the corresponding mask bits. Writing 1s to 0x70 sets them. Both words read back 0.
- R7: irq_o is high exactly when some status bit is 1 while its mask bit is 0. It follows every status, mask and event change in the same cycle that the register changes.
- R8: A pulse on evt_addr_err_i or evt_host_err_i sets status bit 0 or bit 1. If a clearing write to the same bit arrives in the same cycle, the set wins.
- R9: An access to an unmapped offset reads 0 and changes nothing. It gives no error while slave-error enable is 0.
- R10: While slave-error enable is 1, an unmapped access responds with rsp_err_o high and sets status bit 0.
- R11: An access with req_be_i other than 4'hF, or with req_addr_i[1:0] not 0, is treated as unmapped.
- R12: The placeholder word at 0x78 reads 0, ignores writes and never responds with an error.
- R13: Each request is answered in the next cycle with rsp_valid_o high. Read data is taken from the state before that request's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte address |
| req_be_i | input | 4 | Byte enables; only 4'hF is legal |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Error response |
| evt_addr_err_i | input | 1 | Address decode error event pulse |
| evt_host_err_i | input | 1 | Host system error event pulse |
| filt_bypass_o | output | 4 | Bus filter bypass |
| port_strap_o | output | 5 | Port strap bits |
| frame_adj_o | output | 6 | Frame length adjust |
| big_endian_o | output | 1 | Byte order select |
| coherent_o | output | 1 | Coherency select |
| bus_master_en_o | output | 1 | Bus-master enable |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted configuration field shows on its output port in the same cycle as the faulty write. It also shows on the read data one cycle after a read of that word. A wrong status or mask bit can stay hidden at irq_o while the other register covers it. Because of that, the tests read both words back and walk each mask bit on and off against a pending status bit. A decode error that is wrongly flagged or missed shows in rsp_err_o in the response cycle. It also shows as status bit 0 on the next status read.

// File: rtl/usbcfg_pkg.sv
// Package: shared constants and the offset/field tables for the USB host
// wrapper register block. Assumes 32-bit words with byte addressing.
package usbcfg_pkg;
    localparam int REG_W    = 32;
    localparam int FILT_W   = 4;
    localparam int PORT_W   = 5;
    localparam int FADJ_W   = 6;
    localparam int FMAX_W   = 6;
    localparam int NUM_CFG  = 7;
    localparam int NUM_SRC  = 2;
    localparam int NUM_REGS = 12;

    // Register indices; configuration words first, then interrupt words
    localparam int IX_FILT  = 0;
    localparam int IX_PORT  = 1;
    localparam int IX_FADJ  = 2;
    localparam int IX_END   = 3;
    localparam int IX_COH   = 4;
    localparam int IX_BME   = 5;
    localparam int IX_CTRL  = 6;
    localparam int IX_ISTAT = 7;
    localparam int IX_IMASK = 8;
    localparam int IX_IEN   = 9;
    localparam int IX_IDIS  = 10;
    localparam int IX_SPARE = 11;

    localparam logic [FADJ_W-1:0] FADJ_RST = 6'h20;

    function automatic logic [7:0] reg_offset(input int idx);
        case (idx)
            IX_FILT:  return 8'h30;
            IX_PORT:  return 8'h34;
            IX_FADJ:  return 8'h38;
            IX_END:   return 8'h40;
            IX_COH:   return 8'h44;
            IX_BME:   return 8'h48;
            IX_CTRL:  return 8'h60;
            IX_ISTAT: return 8'h64;
            IX_IMASK: return 8'h68;
            IX_IEN:   return 8'h6C;
            IX_IDIS:  return 8'h70;
            default:  return 8'h78;
        endcase
    endfunction

    function automatic int cfg_width(input int idx);
        case (idx)
            IX_FILT: return FILT_W;
            IX_PORT: return PORT_W;
            IX_FADJ: return FADJ_W;
            default: return 1;
        endcase
    endfunction

    function automatic logic [FMAX_W-1:0] cfg_reset(input int idx);
        case (idx)
            IX_FADJ: return FMAX_W'(FADJ_RST);
            IX_BME:  return FMAX_W'(1);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/usbcfg_decode.sv
// Module: address decoder. Produces a one-hot word select for a legal
// full-word aligned access. Assumes ADDR_W is wide enough for offset 0x78.
module usbcfg_decode
    import usbcfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [3:0]          be_i,
    output logic [NUM_REGS-1:0] sel_o,
    output logic                mapped_o
);
    logic legal;
    logic [NUM_REGS-1:0] hit;

    // Only whole, aligned words are legal accesses
    assign legal = (be_i == 4'hF) && (addr_i[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = (addr_i == ADDR_W'(reg_offset(i)));
    end

    assign sel_o    = legal ? hit : '0;
    assign mapped_o = |sel_o;
endmodule

// File: rtl/usbcfg_field.sv
// Module: one configuration field register with a parameterized reset
// value. Assumes a synchronous active-low reset.
module usbcfg_field #(
    parameter int          W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Hold the field; load on write enable
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= RST;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/usbcfg_store.sv
// Module: bank of configuration fields, one per configuration word.
// Each field is zero-extended to FMAX_W. Assumes one write enable per word.
module usbcfg_store
    import usbcfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CFG-1:0]             we_i,
    input  logic [FMAX_W-1:0]              wdata_i,
    output logic [NUM_CFG-1:0][FMAX_W-1:0] fld_o
);
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_fld
        localparam int W = cfg_width(i);
        localparam logic [FMAX_W-1:0] RV = cfg_reset(i);
        logic [W-1:0] q;

        usbcfg_field #(.W(W), .RST(RV[W-1:0])) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .we_i  (we_i[i]),
            .d_i   (wdata_i[W-1:0]),
            .q_o   (q)
        );

        assign fld_o[i] = FMAX_W'(q);
    end
endmodule

// File: rtl/usbcfg_irq.sv
// Module: interrupt group. Sticky status bits are set by events and
// cleared by writing 1. The mask can only be changed through the
// enable/disable commands. Assumes the command strobes are mutually exclusive.
module usbcfg_irq
    import usbcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_we_i,
    input  logic               en_we_i,
    input  logic               dis_we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] status_q, mask_q, clr_bits;

    assign clr_bits = clr_we_i ? wdata_i : '0;

    // Status: clear by write-1, then events set (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | evt_i;
    end

    // Mask: enable command clears bits, disable command sets bits
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '1;
        else if (en_we_i)  mask_q <= mask_q & ~wdata_i;
        else if (dis_we_i) mask_q <= mask_q | wdata_i;
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(status_q & ~mask_q);

    // R1
    reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '1 && status_q == '0 && !irq_o));
    // R4
    status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_q) & ~status_q) & ~$past(clr_bits)) == '0));
    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_we_i || dis_we_i) |-> $stable(mask_q));
    // R8
    event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_i) & ~status_q) == '0));
    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_o);
endmodule

// File: rtl/usb_cfg_regs.sv
// Module: top of the USB host wrapper register block. Decodes register bus
// requests, updates the configuration and interrupt state, and returns a
// registered response one cycle later. Assumes one request per cycle.
module usb_cfg_regs
    import usbcfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [3:0]        req_be_i,
    input  logic [REG_W-1:0]  req_wdata_i,
    output logic              rsp_valid_o,
    output logic [REG_W-1:0]  rsp_rdata_o,
    output logic              rsp_err_o,
    input  logic              evt_addr_err_i,
    input  logic              evt_host_err_i,
    output logic [FILT_W-1:0] filt_bypass_o,
    output logic [PORT_W-1:0] port_strap_o,
    output logic [FADJ_W-1:0] frame_adj_o,
    output logic              big_endian_o,
    output logic              coherent_o,
    output logic              bus_master_en_o,
    output logic              irq_o
);
    logic [NUM_REGS-1:0]             sel;
    logic                            mapped, wr, bad, dec_err, slverr_en;
    logic [NUM_CFG-1:0]              cfg_we;
    logic [NUM_CFG-1:0][FMAX_W-1:0]  fld;
    logic [NUM_SRC-1:0]              status, mask, evt;
    logic [REG_W-1:0]                rdata_c;
    logic                            rsp_valid_q, rsp_err_q;
    logic [REG_W-1:0]                rsp_rdata_q;

    usbcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i   (req_addr_i),
        .be_i     (req_be_i),
        .sel_o    (sel),
        .mapped_o (mapped)
    );

    assign wr      = req_valid_i && req_write_i;
    assign bad     = req_valid_i && !mapped;
    assign dec_err = bad && slverr_en;
    assign cfg_we  = wr ? sel[NUM_CFG-1:0] : '0;

    usbcfg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (req_wdata_i[FMAX_W-1:0]),
        .fld_o   (fld)
    );

    assign slverr_en = fld[IX_CTRL][0];
    assign evt       = {evt_host_err_i, evt_addr_err_i | dec_err};

    usbcfg_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we_i (wr && sel[IX_ISTAT]),
        .en_we_i  (wr && sel[IX_IEN]),
        .dis_we_i (wr && sel[IX_IDIS]),
        .wdata_i  (req_wdata_i[NUM_SRC-1:0]),
        .evt_i    (evt),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq_o)
    );

    // Read mux: OR of selected word values; command and spare words read 0
    always_comb begin
        rdata_c = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (sel[i]) rdata_c = rdata_c | REG_W'(fld[i]);
        if (sel[IX_ISTAT]) rdata_c = rdata_c | REG_W'(status);
        if (sel[IX_IMASK]) rdata_c = rdata_c | REG_W'(mask);
    end

    // Response stage: one-cycle registered reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid_i;
            rsp_rdata_q <= (req_valid_i && !req_write_i) ? rdata_c : '0;
            rsp_err_q   <= dec_err;
        end
    end

    assign rsp_valid_o     = rsp_valid_q;
    assign rsp_rdata_o     = rsp_rdata_q;
    assign rsp_err_o       = rsp_err_q;
    assign filt_bypass_o   = fld[IX_FILT][FILT_W-1:0];
    assign port_strap_o    = fld[IX_PORT][PORT_W-1:0];
    assign frame_adj_o     = fld[IX_FADJ][FADJ_W-1:0];
    assign big_endian_o    = fld[IX_END][0];
    assign coherent_o      = fld[IX_COH][0];
    assign bus_master_en_o = fld[IX_BME][0];

    // R1
    reset_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (frame_adj_o == FADJ_RST && bus_master_en_o && !rsp_valid_o));
    // R10
    err_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> (rsp_valid_o && status[0]));
    // R9
    err_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !$past(slverr_en)) |-> !rsp_err_o);
    // R13
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid_i) |-> rsp_valid_o);
endmodule

// File: tb/usb_cfg_regs_tb.sv
`timescale 1ns/1ps
module usb_cfg_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [7:0]  req_addr_i = '0;
    logic [3:0]  req_be_i = 4'hF;
    logic [31:0] req_wdata_i = '0;
    logic        rsp_valid_o, rsp_err_o;
    logic [31:0] rsp_rdata_o;
    logic        evt_addr_err_i = 1'b0, evt_host_err_i = 1'b0;
    logic [3:0]  filt_bypass_o;
    logic [4:0]  port_strap_o;
    logic [5:0]  frame_adj_o;
    logic        big_endian_o, coherent_o, bus_master_en_o, irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    usb_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_be_i(req_be_i), .req_wdata_i(req_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
        .evt_addr_err_i(evt_addr_err_i), .evt_host_err_i(evt_host_err_i),
        .filt_bypass_o(filt_bypass_o), .port_strap_o(port_strap_o),
        .frame_adj_o(frame_adj_o), .big_endian_o(big_endian_o),
        .coherent_o(coherent_o), .bus_master_en_o(bus_master_en_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One bus access; returns the response sampled after the reply edge
    task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = w; req_addr_i = a;
        req_wdata_i = d; req_be_i = be;
        @(negedge clk);
        req_valid_i = 1'b0; req_write_i = 1'b0; req_be_i = 4'hF;
        rd = rsp_rdata_o; er = rsp_err_o;
        chk("R13 rsp_valid", {31'd0, rsp_valid_o}, 32'd1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er;
        access(1'b1, a, d, 4'hF, rd, er);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic er;
        access(1'b0, a, 32'h0, 4'hF, rd, er);
        chk(tag, rd, exp);
    endtask

    task automatic pulse_host();
        @(negedge clk); evt_host_err_i = 1'b1;
        @(negedge clk); evt_host_err_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 frame_adj", {26'd0, frame_adj_o}, 32'h20);
        chk("R1 bus_master", {31'd0, bus_master_en_o}, 32'd1);
        chk("R1 outs zero", {filt_bypass_o, port_strap_o, big_endian_o, coherent_o}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        rd_chk("R1 mask", 8'h68, 32'h3);
        rd_chk("R1 status", 8'h64, 32'h0);
        rd_chk("R1 fadj word", 8'h38, 32'h20);
    endtask

    task automatic t_cfg();
        wr(8'h30, 32'hFFFF_FFFF);
        chk("R2 filt out", {28'd0, filt_bypass_o}, 32'hF);
        rd_chk("R2 filt rsvd", 8'h30, 32'hF);
        wr(8'h38, 32'hFFFF_FFC5);
        chk("R2 fadj out", {26'd0, frame_adj_o}, 32'h05);
        rd_chk("R2 fadj rd", 8'h38, 32'h05);
        wr(8'h40, 32'h3);
        chk("R2 endian", {31'd0, big_endian_o}, 32'd1);
        rd_chk("R2 endian rd", 8'h40, 32'h1);
        wr(8'h44, 32'h1);
        chk("R2 coh", {31'd0, coherent_o}, 32'd1);
        wr(8'h48, 32'hFFFF_FFFE);
        chk("R2 bme", {31'd0, bus_master_en_o}, 32'd0);
        rd_chk("R2 bme rd", 8'h48, 32'h0);
    endtask

    task automatic t_port();
        wr(8'h34, 32'h0000_0015);
        chk("R3 port bits", {27'd0, port_strap_o}, 32'h15);
        wr(8'h34, 32'hFFFF_FFEA);
        chk("R3 port bits2", {27'd0, port_strap_o}, 32'h0A);
        rd_chk("R3 port rd", 8'h34, 32'h0A);
    endtask

    task automatic t_mask_ro();
        wr(8'h68, 32'h0);
        rd_chk("R5 mask ro", 8'h68, 32'h3);
    endtask

    task automatic t_en_dis();
        wr(8'h6C, 32'h1);
        rd_chk("R6 enable clears", 8'h68, 32'h2);
        rd_chk("R6 enable reads0", 8'h6C, 32'h0);
        wr(8'h70, 32'h1);
        rd_chk("R6 disable sets", 8'h68, 32'h3);
        rd_chk("R6 disable reads0", 8'h70, 32'h0);
    endtask

    task automatic t_irq_w1c();
        pulse_host();
        chk("R8 host sets", {31'd0, irq_o}, 32'd0);
        rd_chk("R8 status", 8'h64, 32'h2);
        wr(8'h6C, 32'h2);
        chk("R7 irq unmasked", {31'd0, irq_o}, 32'd1);
        wr(8'h70, 32'h2);
        chk("R7 irq masked", {31'd0, irq_o}, 32'd0);
        wr(8'h6C, 32'h2);
        wr(8'h64, 32'h0);
        rd_chk("R4 write0 keeps", 8'h64, 32'h2);
        wr(8'h64, 32'h1);
        rd_chk("R4 other bit keeps", 8'h64, 32'h2);
        wr(8'h64, 32'h2);
        chk("R7 irq after clear", {31'd0, irq_o}, 32'd0);
        rd_chk("R4 w1c", 8'h64, 32'h0);
        @(negedge clk); evt_addr_err_i = 1'b1;
        @(negedge clk); evt_addr_err_i = 1'b0;
        rd_chk("R8 addr evt", 8'h64, 32'h1);
        chk("R7 bit0 masked", {31'd0, irq_o}, 32'd0);
        wr(8'h64, 32'h1);
    endtask

    task automatic t_collide();
        @(negedge clk);
        evt_host_err_i = 1'b1;
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 8'h64; req_wdata_i = 32'h2;
        @(negedge clk);
        evt_host_err_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
        chk("R8 set wins irq", {31'd0, irq_o}, 32'd1);
        rd_chk("R8 set wins", 8'h64, 32'h2);
        wr(8'h64, 32'h3);
        wr(8'h70, 32'h3);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; logic er;
        access(1'b0, 8'h3C, 32'h0, 4'hF, rd, er);
        chk("R9 rd zero", rd, 32'h0);
        chk("R9 no err", {31'd0, er}, 32'd0);
        access(1'b1, 8'h50, 32'hFFFF_FFFF, 4'hF, rd, er);
        chk("R9 wr no err", {31'd0, er}, 32'd0);
        rd_chk("R9 status clean", 8'h64, 32'h0);
        access(1'b0, 8'h78, 32'h0, 4'hF, rd, er);
        chk("R12 spare rd", rd, 32'h0);
        wr(8'h78, 32'hFFFF_FFFF);
        rd_chk("R12 spare after wr", 8'h78, 32'h0);
    endtask

    task automatic t_slverr();
        logic [31:0] rd; logic er;
        wr(8'h60, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl rd", 8'h60, 32'h1);
        access(1'b0, 8'h78, 32'h0, 4'hF, rd, er);
        chk("R12 spare no err", {31'd0, er}, 32'd0);
        access(1'b0, 8'h3C, 32'h0, 4'hF, rd, er);
        chk("R10 err", {31'd0, er}, 32'd1);
        chk("R10 rd zero", rd, 32'h0);
        rd_chk("R10 status bit0", 8'h64, 32'h1);
        wr(8'h64, 32'h1);
        access(1'b1, 8'h30, 32'h0, 4'h3, rd, er);
        chk("R11 partial err", {31'd0, er}, 32'd1);
        chk("R11 partial ignored", {28'd0, filt_bypass_o}, 32'hF);
        access(1'b0, 8'h31, 32'h0, 4'hF, rd, er);
        chk("R11 misaligned err", {31'd0, er}, 32'd1);
        chk("R11 misaligned rd", rd, 32'h0);
        wr(8'h60, 32'h0);
        access(1'b0, 8'h31, 32'h0, 4'hF, rd, er);
        chk("R9 err off", {31'd0, er}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_port();
        t_mask_ro();
        t_en_dis();
        t_irq_w1c();
        t_collide();
        t_unmapped();
        t_slverr();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule